// File: doc/BRIEF.md
# Polyphase Coefficient RAM Loader

This block holds the filter coefficients a polyphase scaler uses, in two banks that are swapped at frame boundaries. Software first issues a tap-select write that names the filter type and its tap count. It then streams data writes, each carrying an even and an odd coefficient. An internal pair index and phase index step on their own, so a full table needs no addresses. Every write lands in the bank the scaler is not using. A mode write then asks for the banks to trade places, and the swap takes effect on the next frame-start pulse.

Six filter types share the storage: vertical and horizontal variants for luma, chroma and alpha. The filters are symmetric, so only phases 0 through NUM_PHASES/2 are kept. The read port serves the upper phases by mirroring the phase and reversing the tap order. A chroma mode bit decides whether chroma lookups use their own tables or fall back to the luma tables. The scaler datapath reads one coefficient per cycle for a given type, phase and tap, and gets the result one cycle later.

Top module: `coef_ram_loader`

## Requirements
- R1: A tap-select write (`sel_wr`) records the filter type and tap count and sets both the pair index and the phase index to 0. The following data write therefore lands on phase 0, taps 0 and 1, even after an earlier table was completed.
- R2: A data write stores `even_coef` at tap 2k and `odd_coef` at tap 2k+1 of the current phase, where k is the pair index. Each half is written only when its enable (`even_en`, `odd_en`) is 1; a half whose enable is 0 keeps its old value.
- R3: After each data write the pair index increments. When it passes pair (taps+1)/2-1 it returns to 0 and the phase index increments. Data writes made after the last pair of phase NUM_PHASES/2, or made before any tap-select write, are ignored.
- R4: Bits 1:0 of every stored coefficient are 0, whatever was written.
- R5: Data writes go to the inactive bank (the inverse of `active_bank`). Reads always come from the active bank.
- R6: A mode write (`mode_wr`) requests a bank swap, and the swap happens at the next `frame_start` pulse. Several mode writes before one frame start give a single swap. A frame start with no request pending leaves `active_bank` unchanged.
- R7: A read of phase p > NUM_PHASES/2 returns the stored coefficient of phase NUM_PHASES-p at tap n-1-t, where n is the tap count recorded for that type and t is the requested tap.
- R8: The chroma mode bit is captured on a mode write and applied at the same frame start as the swap. When it is 0, reads of type codes 2 and 3 return the tables of type codes 0 and 1; when it is 1, chroma uses its own tables.
- R9: Type codes are 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical and 5 alpha horizontal. Reads of codes 6 and 7, and reads of a tap at or above the recorded tap count, return 0. Data writes under codes 6 and 7 change no stored coefficient.
- R10: `rd_coef` is registered: it reflects the read inputs sampled at the previous rising clock edge.
- R11: After reset, `active_bank` is 0, no swap is pending, the chroma mode bit is 0 and `rd_coef` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Tap-select write strobe |
| sel_type | input | 3 | Filter type code for the tap-select write |
| sel_taps | input | $clog2(MAX_TAPS+1) | Tap count of the filter being loaded (1..MAX_TAPS) |
| dat_wr | input | 1 | Data write strobe |
| even_coef | input | COEF_W | Even-tap coefficient |
| even_en | input | 1 | Write enable for the even coefficient |
| odd_coef | input | COEF_W | Odd-tap coefficient |
| odd_en | input | 1 | Write enable for the odd coefficient |
| mode_wr | input | 1 | Mode write strobe: request a bank swap |
| mode_chroma | input | 1 | Chroma mode bit carried by the mode write |
| frame_start | input | 1 | Frame-start pulse; applies a pending swap |
| rd_type | input | 3 | Read filter type code |
| rd_phase | input | $clog2(NUM_PHASES) | Read phase |
| rd_tap | input | $clog2(MAX_TAPS) | Read tap |
| rd_coef | output | COEF_W | Coefficient read from the active bank |
| active_bank | output | 1 | Bank the scaler is currently reading |

## Verification
The bench builds the block with NUM_PHASES=8 and MAX_TAPS=4. That gives five stored phases and two pairs per phase, so every mirrored phase (5 to 7) and every tap of every type can be read back exhaustively. The overflow past the last stored phase, the odd-tap-count case and the taps beyond a short filter are all reached within a few dozen writes per table.

// File: rtl/coef_ram_pkg.sv
package coef_ram_pkg;

  localparam int TYPE_W    = 3;
  localparam int NUM_TYPES = 6;

  typedef enum logic [TYPE_W-1:0] {
    FT_LUMA_V = 3'd0,
    FT_LUMA_H = 3'd1,
    FT_CHR_V  = 3'd2,
    FT_CHR_H  = 3'd3,
    FT_ALP_V  = 3'd4,
    FT_ALP_H  = 3'd5
  } filt_type_e;

  // number of even/odd pairs needed for a tap count
  function automatic int pair_count(int taps);
    return (taps + 1) / 2;
  endfunction

  // phase actually held in storage for a requested phase
  function automatic int stored_phase(int ph, int nph);
    return (ph > nph / 2) ? (nph - ph) : ph;
  endfunction

  // tap index in storage; upper phases read the taps back to front
  function automatic int mapped_tap(int ph, int tap, int ntaps, int nph);
    return (ph > nph / 2) ? (ntaps - 1 - tap) : tap;
  endfunction

  function automatic int flat_addr(int bank, int ty, int ph, int pr,
                                   int ntypes, int nstored, int npairs);
    return ((bank * ntypes + ty) * nstored + ph) * npairs + pr;
  endfunction

  // chroma types fall back to luma when chroma tables are not in use
  function automatic logic [TYPE_W-1:0] eff_type(logic [TYPE_W-1:0] ty, logic own_chroma);
    if (!own_chroma && (ty == FT_CHR_V || ty == FT_CHR_H))
      return ty - 3'd2;
    return ty;
  endfunction

endpackage

// File: rtl/coef_wr_index.sv
module coef_wr_index
  import coef_ram_pkg::*;
#(
  parameter int MAX_TAPS   = 8,
  parameter int NUM_PHASES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sel_wr,
  input  logic [TYPE_W-1:0]                 sel_type,
  input  logic [$clog2(MAX_TAPS+1)-1:0]     sel_taps,
  input  logic                              dat_wr,
  output logic                              wr_fire,
  output logic [TYPE_W-1:0]                 wr_type,
  output logic [$clog2(NUM_PHASES/2+1)-1:0] wr_phase,
  output logic [((MAX_TAPS+1)/2 > 1 ? $clog2((MAX_TAPS+1)/2) : 1)-1:0] wr_pair,
  output logic                              taps_wr,
  output logic [$clog2(MAX_TAPS+1)-1:0]     taps_val
);

  localparam int HALF  = NUM_PHASES / 2;
  localparam int SPH_W = $clog2(HALF + 1);
  localparam int PAIRS = (MAX_TAPS + 1) / 2;
  localparam int PR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int TC_W  = $clog2(MAX_TAPS + 1);

  logic [TYPE_W-1:0] type_q;
  logic [TC_W-1:0]   taps_q;
  logic [PR_W-1:0]   pair_q;
  logic [SPH_W-1:0]  phase_q;
  logic              done_q;
  logic [TC_W-1:0]   taps_cl;
  logic [PR_W-1:0]   last_pair;
  logic              sel_ok;

  always_comb begin
    if (sel_taps == '0)
      taps_cl = TC_W'(1);
    else if (int'(sel_taps) > MAX_TAPS)
      taps_cl = TC_W'(MAX_TAPS);
    else
      taps_cl = sel_taps;
    last_pair = PR_W'(pair_count(int'(taps_q)) - 1);
    sel_ok    = int'(sel_type) < NUM_TYPES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q  <= '0;
      taps_q  <= TC_W'(1);
      pair_q  <= '0;
      phase_q <= '0;
      done_q  <= 1'b1;
    end else if (sel_wr) begin
      type_q  <= sel_type;
      taps_q  <= taps_cl;
      pair_q  <= '0;
      phase_q <= '0;
      done_q  <= !sel_ok;
    end else if (dat_wr && !done_q) begin
      if (pair_q == last_pair) begin
        pair_q <= '0;
        if (phase_q == SPH_W'(HALF))
          done_q <= 1'b1;
        else
          phase_q <= phase_q + SPH_W'(1);
      end else begin
        pair_q <= pair_q + PR_W'(1);
      end
    end
  end

  assign wr_fire  = dat_wr && !done_q && !sel_wr;
  assign wr_type  = type_q;
  assign wr_phase = phase_q;
  assign wr_pair  = pair_q;
  assign taps_wr  = sel_wr && sel_ok;
  assign taps_val = taps_cl;

  // R1
  sel_resets_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (pair_q == '0 && phase_q == '0));

  // R3
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pair_q != last_pair) |=> (pair_q == $past(pair_q) + PR_W'(1)));

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pair_q == last_pair && phase_q != SPH_W'(HALF))
      |=> (pair_q == '0 && phase_q == $past(phase_q) + SPH_W'(1)));

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !sel_wr) |=> done_q);

endmodule

// File: rtl/coef_bank_sel.sv
module coef_bank_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_wr,
  input  logic mode_chroma,
  input  logic frame_start,
  output logic active_bank,
  output logic chroma_own
);

  logic active_q;
  logic pend_q;
  logic chroma_pend_q;
  logic chroma_q;
  logic swap_now;

  assign swap_now = frame_start && pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q      <= 1'b0;
      pend_q        <= 1'b0;
      chroma_pend_q <= 1'b0;
      chroma_q      <= 1'b0;
    end else begin
      if (mode_wr)
        chroma_pend_q <= mode_chroma;
      if (swap_now) begin
        active_q <= !active_q;
        chroma_q <= chroma_pend_q;
        pend_q   <= mode_wr;
      end else if (mode_wr) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign active_bank = active_q;
  assign chroma_own  = chroma_q;

  // R6
  bank_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> $past(frame_start && pend_q));

  // R6
  swap_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend_q) |=> (active_q != $past(active_q)));

  // R8
  chroma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_now |=> $stable(chroma_q));

endmodule

// File: rtl/coef_store.sv
module coef_store
  import coef_ram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int MAX_TAPS   = 8,
  parameter int NUM_PHASES = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_fire,
  input  logic                              wr_bank,
  input  logic [TYPE_W-1:0]                 wr_type,
  input  logic [$clog2(NUM_PHASES/2+1)-1:0] wr_phase,
  input  logic [((MAX_TAPS+1)/2 > 1 ? $clog2((MAX_TAPS+1)/2) : 1)-1:0] wr_pair,
  input  logic [COEF_W-1:0]                 even_val,
  input  logic                              even_en,
  input  logic [COEF_W-1:0]                 odd_val,
  input  logic                              odd_en,
  input  logic                              taps_wr,
  input  logic [TYPE_W-1:0]                 taps_type,
  input  logic [$clog2(MAX_TAPS+1)-1:0]     taps_val,
  input  logic                              rd_bank,
  input  logic                              chroma_own,
  input  logic [TYPE_W-1:0]                 rd_type,
  input  logic [$clog2(NUM_PHASES)-1:0]     rd_phase,
  input  logic [$clog2(MAX_TAPS)-1:0]       rd_tap,
  output logic [COEF_W-1:0]                 rd_coef
);

  localparam int HALF   = NUM_PHASES / 2;
  localparam int STORED = HALF + 1;
  localparam int SPH_W  = $clog2(STORED);
  localparam int PAIRS  = (MAX_TAPS + 1) / 2;
  localparam int TW     = $clog2(MAX_TAPS);
  localparam int TC_W   = $clog2(MAX_TAPS + 1);
  localparam int DEPTH  = 2 * NUM_TYPES * STORED * PAIRS;
  localparam int AW     = $clog2(DEPTH);
  localparam logic [COEF_W-1:0] LOW_MASK = ~COEF_W'(3);

  logic [COEF_W-1:0] mem_even [DEPTH];
  logic [COEF_W-1:0] mem_odd  [DEPTH];
  logic [TC_W-1:0]   ntaps_q  [2][NUM_TYPES];

  logic [AW-1:0]     wa;
  logic              wr_ok;

  assign wr_ok = wr_fire && (int'(wr_type) < NUM_TYPES);
  assign wa    = AW'(flat_addr(int'(wr_bank), int'(wr_type), int'(wr_phase),
                               int'(wr_pair), NUM_TYPES, STORED, PAIRS));

  always_ff @(posedge clk) begin
    if (wr_ok && even_en)
      mem_even[wa] <= even_val & LOW_MASK;
    if (wr_ok && odd_en)
      mem_odd[wa] <= odd_val & LOW_MASK;
  end

  // one tap-count table per bank
  for (genvar b = 0; b < 2; b++) begin : g_bank_taps
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int t = 0; t < NUM_TYPES; t++)
          ntaps_q[b][t] <= TC_W'(MAX_TAPS);
      end else if (taps_wr && (int'(wr_bank) == b) && (int'(taps_type) < NUM_TYPES)) begin
        ntaps_q[b][taps_type] <= taps_val;
      end
    end
  end

  logic [TYPE_W-1:0] eff;
  logic [TYPE_W-1:0] eff_i;
  logic              type_ok;
  logic              tap_ok;
  logic [TC_W-1:0]   n_rd;
  logic [SPH_W-1:0]  sp;
  logic [TW-1:0]     mt;
  logic [AW-1:0]     ra;
  logic [COEF_W-1:0] hit;
  logic [COEF_W-1:0] rd_d;

  always_comb begin
    eff     = eff_type(rd_type, chroma_own);
    type_ok = int'(eff) < NUM_TYPES;
    eff_i   = type_ok ? eff : '0;
    n_rd    = ntaps_q[rd_bank][eff_i];
    tap_ok  = type_ok && (int'(rd_tap) < int'(n_rd));
    sp      = SPH_W'(stored_phase(int'(rd_phase), NUM_PHASES));
    mt      = tap_ok ? TW'(mapped_tap(int'(rd_phase), int'(rd_tap), int'(n_rd), NUM_PHASES)) : '0;
    ra      = AW'(flat_addr(int'(rd_bank), int'(eff_i), int'(sp), int'(mt) / 2,
                            NUM_TYPES, STORED, PAIRS));
    hit     = mt[0] ? mem_odd[ra] : mem_even[ra];
    rd_d    = tap_ok ? hit : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_coef <= '0;
    else
      rd_coef <= rd_d;
  end

  // R4
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_coef[1:0] == 2'b00);

  // R9
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_ok |=> (rd_coef == '0));

endmodule

// File: rtl/coef_ram_loader.sv
module coef_ram_loader
  import coef_ram_pkg::*;
#(
  parameter int COEF_W     = 16,
  parameter int NUM_PHASES = 64,
  parameter int MAX_TAPS   = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_wr,
  input  logic [2:0]                    sel_type,
  input  logic [$clog2(MAX_TAPS+1)-1:0] sel_taps,
  input  logic                          dat_wr,
  input  logic [COEF_W-1:0]             even_coef,
  input  logic                          even_en,
  input  logic [COEF_W-1:0]             odd_coef,
  input  logic                          odd_en,
  input  logic                          mode_wr,
  input  logic                          mode_chroma,
  input  logic                          frame_start,
  input  logic [2:0]                    rd_type,
  input  logic [$clog2(NUM_PHASES)-1:0] rd_phase,
  input  logic [$clog2(MAX_TAPS)-1:0]   rd_tap,
  output logic [COEF_W-1:0]             rd_coef,
  output logic                          active_bank
);

  localparam int SPH_W = $clog2(NUM_PHASES / 2 + 1);
  localparam int PAIRS = (MAX_TAPS + 1) / 2;
  localparam int PR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int TC_W  = $clog2(MAX_TAPS + 1);

  logic              wr_fire;
  logic [TYPE_W-1:0] wr_type;
  logic [SPH_W-1:0]  wr_phase;
  logic [PR_W-1:0]   wr_pair;
  logic              taps_wr;
  logic [TC_W-1:0]   taps_val;
  logic              chroma_own;
  logic              wr_bank;

  coef_wr_index #(.MAX_TAPS(MAX_TAPS), .NUM_PHASES(NUM_PHASES)) u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (sel_wr),
    .sel_type (sel_type),
    .sel_taps (sel_taps),
    .dat_wr   (dat_wr),
    .wr_fire  (wr_fire),
    .wr_type  (wr_type),
    .wr_phase (wr_phase),
    .wr_pair  (wr_pair),
    .taps_wr  (taps_wr),
    .taps_val (taps_val)
  );

  coef_bank_sel u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_wr     (mode_wr),
    .mode_chroma (mode_chroma),
    .frame_start (frame_start),
    .active_bank (active_bank),
    .chroma_own  (chroma_own)
  );

  assign wr_bank = !active_bank;

  coef_store #(.COEF_W(COEF_W), .MAX_TAPS(MAX_TAPS), .NUM_PHASES(NUM_PHASES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_bank    (wr_bank),
    .wr_type    (wr_type),
    .wr_phase   (wr_phase),
    .wr_pair    (wr_pair),
    .even_val   (even_coef),
    .even_en    (even_en),
    .odd_val    (odd_coef),
    .odd_en     (odd_en),
    .taps_wr    (taps_wr),
    .taps_type  (sel_type),
    .taps_val   (taps_val),
    .rd_bank    (active_bank),
    .chroma_own (chroma_own),
    .rd_type    (rd_type),
    .rd_phase   (rd_phase),
    .rd_tap     (rd_tap),
    .rd_coef    (rd_coef)
  );

endmodule

// File: tb/sim_coef_ram_loader.sv
`timescale 1ns/1ps
module sim_coef_ram_loader;

  localparam int CW     = 16;
  localparam int NPH    = 8;
  localparam int MT     = 4;
  localparam int HALF   = NPH / 2;
  localparam int STORED = HALF + 1;
  localparam int TCW    = $clog2(MT + 1);
  localparam int PHW    = $clog2(NPH);
  localparam int TW     = $clog2(MT);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           sel_wr = 1'b0;
  logic [2:0]     sel_type = '0;
  logic [TCW-1:0] sel_taps = '0;
  logic           dat_wr = 1'b0;
  logic [CW-1:0]  even_coef = '0;
  logic           even_en = 1'b0;
  logic [CW-1:0]  odd_coef = '0;
  logic           odd_en = 1'b0;
  logic           mode_wr = 1'b0;
  logic           mode_chroma = 1'b0;
  logic           frame_start = 1'b0;
  logic [2:0]     rd_type = '0;
  logic [PHW-1:0] rd_phase = '0;
  logic [TW-1:0]  rd_tap = '0;
  logic [CW-1:0]  rd_coef;
  logic           active_bank;

  coef_ram_loader #(.COEF_W(CW), .NUM_PHASES(NPH), .MAX_TAPS(MT)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_type(sel_type), .sel_taps(sel_taps),
    .dat_wr(dat_wr), .even_coef(even_coef), .even_en(even_en), .odd_coef(odd_coef),
    .odd_en(odd_en), .mode_wr(mode_wr), .mode_chroma(mode_chroma), .frame_start(frame_start),
    .rd_type(rd_type), .rd_phase(rd_phase), .rd_tap(rd_tap), .rd_coef(rd_coef),
    .active_bank(active_bank)
  );

  always #10 clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 0;
  int mdl [2][6][STORED][MT];
  int ntp [2][6];
  int act_m = 0;
  int chr_m = 0;

  task automatic check(string req, int got, int exp);
    tests_run++;
    if (got != exp) begin
      tests_failed++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int val(int base, int ph, int tap);
    return (base + ph * 16 + tap * 4 + 3) & 'hffff;
  endfunction

  function automatic int exp_rd(int ty, int ph, int tap);
    int e, n, sp, mt;
    e = (chr_m == 0 && (ty == 2 || ty == 3)) ? ty - 2 : ty;
    if (e > 5) return 0;
    n = ntp[act_m][e];
    if (tap >= n) return 0;
    sp = (ph > HALF) ? NPH - ph : ph;
    mt = (ph > HALF) ? n - 1 - tap : tap;
    return mdl[act_m][e][sp][mt];
  endfunction

  task automatic do_sel(int ty, int taps);
    sel_wr = 1'b1; sel_type = 3'(ty); sel_taps = TCW'(taps);
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic wpair(int e, bit ee, int o, bit oe);
    dat_wr = 1'b1; even_coef = CW'(e); even_en = ee; odd_coef = CW'(o); odd_en = oe;
    @(negedge clk);
    dat_wr = 1'b0; even_en = 1'b0; odd_en = 1'b0;
  endtask

  task automatic load(int ty, int taps, int base);
    int ib;
    ib = 1 - act_m;
    do_sel(ty, taps);
    for (int ph = 0; ph < STORED; ph++) begin
      for (int pr = 0; pr < (taps + 1) / 2; pr++) begin
        int e, o;
        e = val(base, ph, 2 * pr);
        o = (2 * pr + 1 < taps) ? val(base, ph, 2 * pr + 1) : 0;
        wpair(e, 1'b1, o, 1'b1);
        if (ty < 6) begin
          mdl[ib][ty][ph][2 * pr] = e & ~3;
          if (2 * pr + 1 < MT) mdl[ib][ty][ph][2 * pr + 1] = o & ~3;
        end
      end
    end
    if (ty < 6) ntp[ib][ty] = taps;
  endtask

  task automatic swap(bit chroma);
    mode_wr = 1'b1; mode_chroma = chroma;
    @(negedge clk);
    mode_wr = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    act_m = 1 - act_m;
    chr_m = chroma;
  endtask

  task automatic rd(int ty, int ph, int tap, output int got);
    rd_type = 3'(ty); rd_phase = PHW'(ph); rd_tap = TW'(tap);
    @(negedge clk);
    got = int'(rd_coef);
  endtask

  task automatic rd_chk(string req, int ty, int ph, int tap);
    int got;
    rd(ty, ph, tap, got);
    check(req, got, exp_rd(ty, ph, tap));
  endtask

  task automatic chk_type(string req, int ty);
    for (int ph = 0; ph < NPH; ph++)
      for (int tap = 0; tap < MT; tap++)
        rd_chk(req, ty, ph, tap);
  endtask

  task automatic t_reset();
    check("R11 active_bank after reset", int'(active_bank), 0);
    check("R11 rd_coef after reset", int'(rd_coef), 0);
  endtask

  task automatic t_load_swap();
    int got;
    load(0, 4, 'h100);
    load(1, 3, 'h200);
    load(2, 4, 'h300);
    load(3, 2, 'h400);
    load(4, 1, 'h500);
    load(5, 4, 'h600);
    mode_wr = 1'b1; mode_chroma = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    @(negedge clk);
    check("R6 no swap before frame start", int'(active_bank), 0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    act_m = 1; chr_m = 1;
    check("R6 swap at frame start", int'(active_bank), 1);
    for (int ty = 0; ty < 6; ty++) chk_type("R2 R7 R9 table readback", ty);
    rd(0, 0, 0, got);
    check("R4 low bits cleared", got & 3, 0);
    rd(0, 5, 0, got);
    check("R7 mirrored phase", got, val('h100, 3, 3) & ~3);
    rd(1, 6, 0, got);
    check("R7 mirror with odd tap count", got, val('h200, 2, 2) & ~3);
  endtask

  task automatic t_latency();
    int got;
    rd(0, 1, 0, got);
    rd_tap = TW'(1);
    #2;
    check("R10 output holds before edge", int'(rd_coef), val('h100, 1, 0) & ~3);
    @(negedge clk);
    check("R10 output after one edge", int'(rd_coef), val('h100, 1, 1) & ~3);
  endtask

  task automatic t_inactive();
    int got;
    load(0, 4, 'h800);
    chk_type("R5 active bank unaffected by writes", 0);
    swap(1'b0);
    check("R6 second swap", int'(active_bank), 0);
    chk_type("R5 new bank readback", 0);
    chk_type("R8 chroma reuses luma", 2);
    rd(2, 1, 2, got);
    check("R8 chroma vertical from luma vertical", got, val('h800, 1, 2) & ~3);
  endtask

  task automatic t_enables();
    do_sel(5, 4);
    wpair('h1111, 1'b0, 'h7777, 1'b1);
    wpair('h5555, 1'b1, 'h2222, 1'b0);
    mdl[1][5][0][1] = 'h7774;
    mdl[1][5][0][2] = 'h5554;
    swap(1'b1);
    rd_chk("R2 even disabled keeps old", 5, 0, 0);
    rd_chk("R1 reselect restarts at phase 0 pair 0", 5, 0, 1);
    rd_chk("R2 even enabled stored", 5, 0, 2);
    rd_chk("R2 odd disabled keeps old", 5, 0, 3);
    rd_chk("R1 later phase untouched", 5, 1, 0);
  endtask

  task automatic t_overflow();
    load(4, 2, 'hA00);
    wpair('hFFFF, 1'b1, 'hFFFF, 1'b1);
    wpair('hFFFF, 1'b1, 'hFFFF, 1'b1);
    wpair('hFFFF, 1'b1, 'hFFFF, 1'b1);
    swap(1'b1);
    chk_type("R3 writes past last phase ignored", 4);
    rd_chk("R9 tap beyond count", 4, 2, 3);
  endtask

  task automatic t_invalid();
    int got;
    do_sel(6, 4);
    wpair('h1234, 1'b1, 'h4321, 1'b1);
    wpair('h1234, 1'b1, 'h4321, 1'b1);
    rd(6, 0, 0, got);
    check("R9 type code 6 reads zero", got, 0);
    rd(7, 1, 1, got);
    check("R9 type code 7 reads zero", got, 0);
    swap(1'b1);
    for (int ty = 0; ty < 6; ty++) chk_type("R9 invalid type writes ignored", ty);
  endtask

  task automatic t_mode_rules();
    mode_wr = 1'b1; mode_chroma = 1'b1;
    @(negedge clk);
    @(negedge clk);
    mode_wr = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    act_m = 1 - act_m;
    check("R6 two requests give one swap", int'(active_bank), act_m);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    @(negedge clk);
    check("R6 frame start without request", int'(active_bank), act_m);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 2; b++)
      for (int t = 0; t < 6; t++)
        ntp[b][t] = MT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_swap();
    t_latency();
    t_inactive();
    t_enables();
    t_overflow();
    t_invalid();
    t_mode_rules();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule